// File: doc/BRIEF.md
# Display Mode Timing Converter

This block takes one raw display mode and works out the timing values an output interface needs to scan it: active width and height, front and back porches, sync pulse widths and sync polarities. It also works out where the next frame's pixel fetch should begin, measured as a vertical-sync-relative pixel counter value. Each axis is described by its display, sync start, sync end and total positions. Flags give the negative-sync options, the interface kind, a wide-bus setting and a split (dual-pipe) setting.

A one-cycle `start` captures all inputs. The block checks the mode for consistency and derives the per-axis values, with interface-specific adjustments. It then chooses how many prefetch lines to place in the vertical front porch and multiplies the two frame totals to find the fetch start position. When every output holds its final value, `done` pulses for one cycle. The outputs keep those values until the next accepted request. A rejected mode raises `mode_err` and drives every timing output to zero.

Top module: `mode_timing_conv`

## Requirements
- R1: A mode is rejected when, on either axis, total < sync end, sync start < display, or sync end < sync start. A rejected mode gives `mode_err`=1 at `done`, and every timing, skew, prefetch and warning output is 0.
- R2: For each axis: back porch = total − sync end, front porch = sync start − display, pulse = sync end − sync start, and active size = display.
- R3: `h_pol`/`v_pol` equal `hsync_neg`/`vsync_neg`. When `intf_kind`=1 (serial panel link), both are 0.
- R4: When `split_mode`=1, the horizontal display, sync start, sync end, total and skew inputs are each shifted right by one before any other step. `h_skew_out` carries the resulting skew.
- R5: When `intf_kind`=2 (packet display port) and `wide_bus`=1, each axis's front porch is added to its back porch and the front porch becomes 0. After that, the horizontal active width, back porch, front porch and pulse are each shifted right by one.
- R6: Let W=`wc_lines` and S = converted vertical back porch + vertical pulse. The prefetch line count is 0 if S ≥ W. Otherwise it is the whole vertical front porch if that is smaller than W−S, in which case `low_porch`=1. Otherwise it is W−S.
- R7: Horizontal total = converted width + both horizontal porches + horizontal pulse; vertical total is formed the same way. If the prefetch line count is nonzero, `fetch_en`=1 and `fetch_start` = (vertical total − lines) × horizontal total + 1. Otherwise both are 0.
- R8: `border_clr` is always 0 and `underflow_clr` is always all ones (0xff).
- R9: `done` is high for exactly one cycle per accepted request, and never while `busy` is high. A `start` seen while `busy` is high is ignored.
- R10: A `start` in the same cycle as `done` is accepted and begins a new conversion.
- R11: After reset, `busy`, `done`, `mode_err`, `fetch_en`, `low_porch` and all timing outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a conversion of the present inputs |
| h_active_in | input | TW | Horizontal display size |
| h_sync_beg | input | TW | Horizontal sync start position |
| h_sync_fin | input | TW | Horizontal sync end position |
| h_total_in | input | TW | Horizontal total |
| h_skew_in | input | TW | Horizontal sync skew |
| v_active_in | input | TW | Vertical display size |
| v_sync_beg | input | TW | Vertical sync start position |
| v_sync_fin | input | TW | Vertical sync end position |
| v_total_in | input | TW | Vertical total |
| hsync_neg | input | 1 | Horizontal sync is active low |
| vsync_neg | input | 1 | Vertical sync is active low |
| intf_kind | input | 2 | 0 other, 1 serial panel link, 2 packet display port |
| wide_bus | input | 1 | Wide-bus pixel path selected |
| split_mode | input | 1 | Block drives one half of a split pipe |
| wc_lines | input | TW | Worst-case prefetch line need |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion pulse |
| mode_err | output | 1 | Mode rejected |
| act_width | output | TW | Active width |
| act_height | output | TW | Active height |
| h_back | output | TW | Horizontal back porch |
| h_front | output | TW | Horizontal front porch |
| h_pulse | output | TW | Horizontal sync pulse width |
| v_back | output | TW | Vertical back porch |
| v_front | output | TW | Vertical front porch |
| v_pulse | output | TW | Vertical sync pulse width |
| h_pol | output | 1 | Horizontal sync polarity |
| v_pol | output | 1 | Vertical sync polarity |
| h_skew_out | output | TW | Horizontal skew after split adjustment |
| border_clr | output | CW | Border colour |
| underflow_clr | output | CW | Underflow colour |
| fetch_en | output | 1 | Prefetch enabled |
| fetch_start | output | FW | Fetch start counter value |
| low_porch | output | 1 | Front porch too short for the prefetch need |

## Verification
The completion pulse of one conversion and the acceptance of the next request can fall in the same cycle. The bench provokes this by raising `start` with a new mode exactly when it sees `done`. It judges the case by checking that `busy` rises on the following cycle and that the second result, which has prefetch disabled, replaces the first. The opposite case is also covered: `start` is held high for the whole of a busy period with an invalid mode on the inputs. The first result must appear unchanged, and no further `done` may follow.

// File: rtl/mtc_pkg.sv
package mtc_pkg;
   typedef enum logic [1:0] {ST_IDLE, ST_CALC, ST_MUL, ST_DONE} mtc_state_e;
   localparam logic [1:0] KIND_SERIAL = 2'd1;
   localparam logic [1:0] KIND_PACKET = 2'd2;
endpackage

// File: rtl/mtc_convert.sv
module mtc_convert
   import mtc_pkg::*;
#(
   parameter int TW = 16
) (
   input  logic [TW-1:0] hd_i, hs_i, he_i, ht_i, hk_i,
   input  logic [TW-1:0] vd_i, vs_i, ve_i, vt_i,
   input  logic          hneg_i, vneg_i, wide_i, split_i,
   input  logic [1:0]    kind_i,
   output logic          bad_o,
   output logic [TW-1:0] wid_o, hgt_o, hbp_o, hfp_o, hpw_o,
   output logic [TW-1:0] vbp_o, vfp_o, vpw_o, skew_o,
   output logic          hpol_o, vpol_o
);
   logic [TW-1:0] hd, hs, he, ht;
   logic [TW:0]   hbp_f, vbp_f;
   logic          fold;

   // R4: halve the horizontal inputs for a split pipe
   assign hd     = split_i ? (hd_i >> 1) : hd_i;
   assign hs     = split_i ? (hs_i >> 1) : hs_i;
   assign he     = split_i ? (he_i >> 1) : he_i;
   assign ht     = split_i ? (ht_i >> 1) : ht_i;
   assign skew_o = split_i ? (hk_i >> 1) : hk_i;

   // R1: ordering checks on both axes
   assign bad_o = (ht < he) || (hs < hd) || (he < hs) ||
                  (vt_i < ve_i) || (vs_i < vd_i) || (ve_i < vs_i);

   assign fold  = (kind_i == KIND_PACKET) && wide_i;

   // R2/R5: porches, optionally folded and halved
   assign hbp_f = {1'b0, ht - he} + (fold ? {1'b0, hs - hd} : '0);
   assign vbp_f = {1'b0, vt_i - ve_i} + (fold ? {1'b0, vs_i - vd_i} : '0);

   assign wid_o = fold ? (hd >> 1) : hd;
   assign hbp_o = fold ? hbp_f[TW:1] : hbp_f[TW-1:0];
   assign hfp_o = fold ? '0 : (hs - hd);
   assign hpw_o = fold ? ((he - hs) >> 1) : (he - hs);
   assign hgt_o = vd_i;
   assign vbp_o = vbp_f[TW-1:0];
   assign vfp_o = fold ? '0 : (vs_i - vd_i);
   assign vpw_o = ve_i - vs_i;

   // R3: serial panel link only takes active-high syncs
   assign hpol_o = (kind_i == KIND_SERIAL) ? 1'b0 : hneg_i;
   assign vpol_o = (kind_i == KIND_SERIAL) ? 1'b0 : vneg_i;
endmodule

// File: rtl/mtc_prefetch.sv
module mtc_prefetch #(
   parameter int TW = 16
) (
   input  logic [TW-1:0] vbp_i, vpw_i, vfp_i, wc_i,
   output logic [TW-1:0] lines_o,
   output logic          low_o
);
   logic [TW:0] sof, need;

   assign sof  = {1'b0, vbp_i} + {1'b0, vpw_i};
   assign need = {1'b0, wc_i} - sof;

   // R6: clamp the prefetch need into the front porch
   always_comb begin
      lines_o = '0;
      low_o   = 1'b0;
      if (sof < {1'b0, wc_i}) begin
         if ({1'b0, vfp_i} < need) begin
            lines_o = vfp_i;
            low_o   = 1'b1;
         end else begin
            lines_o = need[TW-1:0];
         end
      end
   end
endmodule

// File: rtl/mtc_mult.sv
module mtc_mult #(
   parameter int TW  = 16,
   parameter int FW  = 32,
   parameter bit SEQ = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic [TW-1:0] a,
   input  logic [TW-1:0] b,
   output logic [FW-1:0] prod,
   output logic          vld
);
   localparam int CNW = $clog2(TW) + 1;

   if (FW < 2 * TW) begin : g_bad_width
      $error("mtc_mult: FW must hold a full TW x TW product");
   end

   if (SEQ) begin : g_shift_add
      logic [FW-1:0]  acc, mc;
      logic [TW-1:0]  mp;
      logic [CNW-1:0] cnt;
      logic           run;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            acc <= '0; mc <= '0; mp <= '0; cnt <= '0; run <= 1'b0; vld <= 1'b0;
         end else begin
            vld <= 1'b0;
            if (go) begin
               acc <= '0;
               mc  <= FW'(a);
               mp  <= b;
               cnt <= '0;
               run <= 1'b1;
            end else if (run) begin
               if (mp[0]) acc <= acc + mc;
               mc  <= mc << 1;
               mp  <= mp >> 1;
               cnt <= cnt + 1'b1;
               if (cnt == CNW'(TW - 1)) begin
                  run <= 1'b0;
                  vld <= 1'b1;
               end
            end
         end
      end
      assign prod = acc;
   end else begin : g_single
      logic [FW-1:0] p_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            p_q <= '0; vld <= 1'b0;
         end else begin
            vld <= go;
            if (go) p_q <= FW'(a) * FW'(b);
         end
      end
      assign prod = p_q;
   end
endmodule

// File: rtl/mode_timing_conv.sv
module mode_timing_conv
   import mtc_pkg::*;
#(
   parameter int TW      = 16,
   parameter int FW      = 32,
   parameter int CW      = 8,
   parameter bit MUL_SEQ = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [TW-1:0] h_active_in,
   input  logic [TW-1:0] h_sync_beg,
   input  logic [TW-1:0] h_sync_fin,
   input  logic [TW-1:0] h_total_in,
   input  logic [TW-1:0] h_skew_in,
   input  logic [TW-1:0] v_active_in,
   input  logic [TW-1:0] v_sync_beg,
   input  logic [TW-1:0] v_sync_fin,
   input  logic [TW-1:0] v_total_in,
   input  logic          hsync_neg,
   input  logic          vsync_neg,
   input  logic [1:0]    intf_kind,
   input  logic          wide_bus,
   input  logic          split_mode,
   input  logic [TW-1:0] wc_lines,
   output logic          busy,
   output logic          done,
   output logic          mode_err,
   output logic [TW-1:0] act_width,
   output logic [TW-1:0] act_height,
   output logic [TW-1:0] h_back,
   output logic [TW-1:0] h_front,
   output logic [TW-1:0] h_pulse,
   output logic [TW-1:0] v_back,
   output logic [TW-1:0] v_front,
   output logic [TW-1:0] v_pulse,
   output logic          h_pol,
   output logic          v_pol,
   output logic [TW-1:0] h_skew_out,
   output logic [CW-1:0] border_clr,
   output logic [CW-1:0] underflow_clr,
   output logic          fetch_en,
   output logic [FW-1:0] fetch_start,
   output logic          low_porch
);
   localparam int SW = TW + 2;

   if (TW < 2 || CW < 1) begin : g_bad_param
      $error("mode_timing_conv: TW must be at least 2 and CW at least 1");
   end

   mtc_state_e    st;
   logic [TW-1:0] hd_q, hs_q, he_q, ht_q, hk_q, vd_q, vs_q, ve_q, vt_q, wc_q;
   logic          hn_q, vn_q, wb_q, sp_q;
   logic [1:0]    kd_q;
   logic          accept, mul_go, mul_vld;

   logic          c_bad, c_hpol, c_vpol, p_low;
   logic [TW-1:0] c_wid, c_hgt, c_hbp, c_hfp, c_hpw, c_vbp, c_vfp, c_vpw, c_skew;
   logic [TW-1:0] p_lines;
   logic [SW-1:0] htot, vtot;
   logic [FW-1:0] prod;

   assign accept        = start && (st == ST_IDLE || st == ST_DONE);
   assign busy          = (st == ST_CALC) || (st == ST_MUL);
   assign done          = (st == ST_DONE);
   assign border_clr    = '0;
   assign underflow_clr = '1;

   mtc_convert #(.TW(TW)) u_conv (
      .hd_i(hd_q), .hs_i(hs_q), .he_i(he_q), .ht_i(ht_q), .hk_i(hk_q),
      .vd_i(vd_q), .vs_i(vs_q), .ve_i(ve_q), .vt_i(vt_q),
      .hneg_i(hn_q), .vneg_i(vn_q), .wide_i(wb_q), .split_i(sp_q), .kind_i(kd_q),
      .bad_o(c_bad), .wid_o(c_wid), .hgt_o(c_hgt), .hbp_o(c_hbp), .hfp_o(c_hfp),
      .hpw_o(c_hpw), .vbp_o(c_vbp), .vfp_o(c_vfp), .vpw_o(c_vpw), .skew_o(c_skew),
      .hpol_o(c_hpol), .vpol_o(c_vpol)
   );

   mtc_prefetch #(.TW(TW)) u_pf (
      .vbp_i(c_vbp), .vpw_i(c_vpw), .vfp_i(c_vfp), .wc_i(wc_q),
      .lines_o(p_lines), .low_o(p_low)
   );

   // R7: frame totals from the converted values
   assign htot = SW'(c_wid) + SW'(c_hbp) + SW'(c_hfp) + SW'(c_hpw);
   assign vtot = SW'(c_hgt) + SW'(c_vbp) + SW'(c_vfp) + SW'(c_vpw);

   mtc_mult #(.TW(TW), .FW(FW), .SEQ(MUL_SEQ)) u_mul (
      .clk(clk), .rst_n(rst_n), .go(mul_go),
      .a(vtot[TW-1:0] - p_lines), .b(htot[TW-1:0]),
      .prod(prod), .vld(mul_vld)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_IDLE;
         {hd_q, hs_q, he_q, ht_q, hk_q, vd_q, vs_q, ve_q, vt_q, wc_q} <= '0;
         {hn_q, vn_q, wb_q, sp_q, kd_q} <= '0;
         mul_go <= 1'b0;
         mode_err <= 1'b0;
         {act_width, act_height, h_back, h_front, h_pulse} <= '0;
         {v_back, v_front, v_pulse, h_skew_out} <= '0;
         {h_pol, v_pol, fetch_en, low_porch} <= '0;
         fetch_start <= '0;
      end else begin
         mul_go <= 1'b0;
         if (accept) begin
            hd_q <= h_active_in; hs_q <= h_sync_beg; he_q <= h_sync_fin;
            ht_q <= h_total_in;  hk_q <= h_skew_in;
            vd_q <= v_active_in; vs_q <= v_sync_beg; ve_q <= v_sync_fin;
            vt_q <= v_total_in;  wc_q <= wc_lines;
            hn_q <= hsync_neg; vn_q <= vsync_neg; wb_q <= wide_bus;
            sp_q <= split_mode; kd_q <= intf_kind;
            st   <= ST_CALC;
         end else begin
            unique case (st)
               ST_CALC: begin
                  fetch_en    <= 1'b0;
                  fetch_start <= '0;
                  mode_err    <= c_bad;
                  if (c_bad) begin
                     {act_width, act_height, h_back, h_front, h_pulse} <= '0;
                     {v_back, v_front, v_pulse, h_skew_out} <= '0;
                     {h_pol, v_pol, low_porch} <= '0;
                     st <= ST_DONE;
                  end else begin
                     act_width <= c_wid; act_height <= c_hgt;
                     h_back <= c_hbp; h_front <= c_hfp; h_pulse <= c_hpw;
                     v_back <= c_vbp; v_front <= c_vfp; v_pulse <= c_vpw;
                     h_skew_out <= c_skew; h_pol <= c_hpol; v_pol <= c_vpol;
                     low_porch <= p_low;
                     if (p_lines != '0) begin
                        mul_go <= 1'b1;
                        st     <= ST_MUL;
                     end else begin
                        st <= ST_DONE;
                     end
                  end
               end
               ST_MUL: begin
                  if (mul_vld) begin
                     fetch_en    <= 1'b1;
                     fetch_start <= prod + 1'b1;
                     st          <= ST_DONE;
                  end
               end
               ST_DONE: st <= ST_IDLE;
               default: st <= ST_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/mtc_chk.sv
module mtc_chk #(
   parameter int TW = 16,
   parameter int FW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          done,
   input logic          mode_err,
   input logic [TW-1:0] act_width,
   input logic [TW-1:0] act_height,
   input logic [TW-1:0] h_back,
   input logic [TW-1:0] v_back,
   input logic          fetch_en,
   input logic [FW-1:0] fetch_start,
   input logic          low_porch
);
   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r9_busy_no_done: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !done);

   a_r1_err_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
      (done && mode_err) |-> (act_width == '0 && act_height == '0 && h_back == '0 &&
                              v_back == '0 && !fetch_en && !low_porch));

   a_r7_fetch_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !fetch_en) |-> (fetch_start == '0));

   a_r7_fetch_on_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      (done && fetch_en) |-> (fetch_start != '0));

   a_r9_stable_until_next: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !done && $past(!busy)) |-> $stable(fetch_start));
endmodule

bind mode_timing_conv mtc_chk #(.TW(TW), .FW(FW)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .mode_err(mode_err),
   .act_width(act_width), .act_height(act_height), .h_back(h_back),
   .v_back(v_back), .fetch_en(fetch_en), .fetch_start(fetch_start),
   .low_porch(low_porch)
);

// File: tb/tb_mode_timing_conv.sv
module tb_mode_timing_conv;
   localparam int TW = 16;
   localparam int FW = 32;
   localparam int CW = 8;

   typedef struct packed {
      logic [15:0] hd, hs, he, ht, hk, vd, vs, ve, vt;
      logic        nh, nv;
      logic [1:0]  kind;
      logic        wb, sp;
      logic [15:0] wc;
      logic        e_err, e_low;
      logic [31:0] e_fs;
   } vec_t;

   typedef struct packed {
      logic        err;
      logic [15:0] w, h, hb, hf, hp, vb, vf, vp, sk;
      logic        hpl, vpl, fen, low;
      logic [31:0] fs;
   } exp_t;

   // kind: 0 other, 1 serial panel link, 2 packet display port
   localparam vec_t TBL [9] = '{
      '{16'd100, 16'd110, 16'd120, 16'd150, 16'd0, 16'd50, 16'd53, 16'd55, 16'd60,
        1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 16'd10, 1'b0, 1'b0, 32'd8551},
      '{16'd100, 16'd110, 16'd120, 16'd150, 16'd0, 16'd50, 16'd53, 16'd55, 16'd60,
        1'b1, 1'b1, 2'd1, 1'b0, 1'b0, 16'd20, 1'b0, 1'b1, 32'd8551},
      '{16'd100, 16'd110, 16'd120, 16'd150, 16'd0, 16'd50, 16'd53, 16'd55, 16'd60,
        1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 16'd5, 1'b0, 1'b0, 32'd0},
      '{16'd200, 16'd220, 16'd240, 16'd300, 16'd6, 16'd50, 16'd53, 16'd55, 16'd60,
        1'b0, 1'b1, 2'd0, 1'b0, 1'b1, 16'd10, 1'b0, 1'b0, 32'd8551},
      '{16'd100, 16'd110, 16'd120, 16'd150, 16'd0, 16'd50, 16'd53, 16'd55, 16'd60,
        1'b0, 1'b0, 2'd2, 1'b1, 1'b0, 16'd12, 1'b0, 1'b1, 32'd0},
      '{16'd100, 16'd110, 16'd120, 16'd150, 16'd0, 16'd50, 16'd53, 16'd55, 16'd60,
        1'b0, 1'b0, 2'd2, 1'b0, 1'b0, 16'd10, 1'b0, 1'b0, 32'd8551},
      '{16'd100, 16'd90, 16'd120, 16'd150, 16'd4, 16'd50, 16'd53, 16'd55, 16'd60,
        1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 16'd10, 1'b1, 1'b0, 32'd0},
      '{16'd100, 16'd110, 16'd120, 16'd150, 16'd0, 16'd50, 16'd53, 16'd55, 16'd54,
        1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 16'd10, 1'b1, 1'b0, 32'd0},
      '{16'd1920, 16'd2008, 16'd2052, 16'd2200, 16'd0, 16'd1080, 16'd1084, 16'd1089, 16'd1125,
        1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 16'd60, 1'b0, 1'b1, 32'd2466201}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [TW-1:0] h_active_in = '0, h_sync_beg = '0, h_sync_fin = '0, h_total_in = '0, h_skew_in = '0;
   logic [TW-1:0] v_active_in = '0, v_sync_beg = '0, v_sync_fin = '0, v_total_in = '0, wc_lines = '0;
   logic          hsync_neg = 1'b0, vsync_neg = 1'b0, wide_bus = 1'b0, split_mode = 1'b0;
   logic [1:0]    intf_kind = 2'd0;
   logic          busy, done, mode_err, h_pol, v_pol, fetch_en, low_porch;
   logic [TW-1:0] act_width, act_height, h_back, h_front, h_pulse, v_back, v_front, v_pulse, h_skew_out;
   logic [CW-1:0] border_clr, underflow_clr;
   logic [FW-1:0] fetch_start;

   int checks = 0;
   int failures = 0;
   int cycles = 0;

   always #10 clk = ~clk;

   mode_timing_conv #(.TW(TW), .FW(FW), .CW(CW)) dut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .h_active_in(h_active_in), .h_sync_beg(h_sync_beg), .h_sync_fin(h_sync_fin),
      .h_total_in(h_total_in), .h_skew_in(h_skew_in),
      .v_active_in(v_active_in), .v_sync_beg(v_sync_beg), .v_sync_fin(v_sync_fin),
      .v_total_in(v_total_in), .hsync_neg(hsync_neg), .vsync_neg(vsync_neg),
      .intf_kind(intf_kind), .wide_bus(wide_bus), .split_mode(split_mode),
      .wc_lines(wc_lines), .busy(busy), .done(done), .mode_err(mode_err),
      .act_width(act_width), .act_height(act_height), .h_back(h_back),
      .h_front(h_front), .h_pulse(h_pulse), .v_back(v_back), .v_front(v_front),
      .v_pulse(v_pulse), .h_pol(h_pol), .v_pol(v_pol), .h_skew_out(h_skew_out),
      .border_clr(border_clr), .underflow_clr(underflow_clr),
      .fetch_en(fetch_en), .fetch_start(fetch_start), .low_porch(low_porch)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 100000) begin
         failures = failures + 1;
         $display("FAIL watchdog expired: actual=%0d cycles expected=<100000", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Expected values from the requirement text
   function automatic exp_t model(vec_t v);
      exp_t e;
      int hd, hs, he, ht, hk, hb, hf, hp, vb, vf, vp, s, need, lines, htot, vtot;
      e = '0;
      hd = v.sp ? int'(v.hd) / 2 : int'(v.hd);
      hs = v.sp ? int'(v.hs) / 2 : int'(v.hs);
      he = v.sp ? int'(v.he) / 2 : int'(v.he);
      ht = v.sp ? int'(v.ht) / 2 : int'(v.ht);
      hk = v.sp ? int'(v.hk) / 2 : int'(v.hk);
      if (ht < he || hs < hd || he < hs || v.vt < v.ve || v.vs < v.vd || v.ve < v.vs) begin
         e.err = 1'b1;
         return e;
      end
      hb = ht - he; hf = hs - hd; hp = he - hs;
      vb = int'(v.vt) - int'(v.ve); vf = int'(v.vs) - int'(v.vd); vp = int'(v.ve) - int'(v.vs);
      if (v.kind == 2'd2 && v.wb) begin
         hb = hb + hf; hf = 0; vb = vb + vf; vf = 0;
         hd = hd / 2; hb = hb / 2; hp = hp / 2;
      end
      e.w = 16'(hd); e.h = v.vd; e.hb = 16'(hb); e.hf = 16'(hf); e.hp = 16'(hp);
      e.vb = 16'(vb); e.vf = 16'(vf); e.vp = 16'(vp); e.sk = 16'(hk);
      e.hpl = (v.kind == 2'd1) ? 1'b0 : v.nh;
      e.vpl = (v.kind == 2'd1) ? 1'b0 : v.nv;
      s = vb + vp; lines = 0;
      if (s < int'(v.wc)) begin
         need = int'(v.wc) - s;
         if (vf < need) begin lines = vf; e.low = 1'b1; end
         else lines = need;
      end
      htot = hd + hb + hf + hp;
      vtot = int'(v.vd) + vb + vf + vp;
      if (lines != 0) begin
         e.fen = 1'b1;
         e.fs = 32'((vtot - lines) * htot + 1);
      end
      return e;
   endfunction

   task automatic drive(input vec_t v);
      h_active_in = v.hd; h_sync_beg = v.hs; h_sync_fin = v.he; h_total_in = v.ht;
      h_skew_in = v.hk; v_active_in = v.vd; v_sync_beg = v.vs; v_sync_fin = v.ve;
      v_total_in = v.vt; hsync_neg = v.nh; vsync_neg = v.nv; intf_kind = v.kind;
      wide_bus = v.wb; split_mode = v.sp; wc_lines = v.wc;
   endtask

   task automatic wait_done(input string req);
      int n = 0;
      while (!done && n < 400) begin
         @(negedge clk);
         n++;
      end
      checks++;
      if (!done) begin
         failures++;
         $display("FAIL %s: actual=no done expected=done within 400 cycles", req);
      end
   endtask

   task automatic compare(input vec_t v, input string req);
      exp_t e;
      e = model(v);
      chk({req, " R1 mode_err"}, 32'(mode_err), 32'(e.err));
      chk({req, " R2 width"}, 32'(act_width), 32'(e.w));
      chk({req, " R2 height"}, 32'(act_height), 32'(e.h));
      chk({req, " R2 h_back"}, 32'(h_back), 32'(e.hb));
      chk({req, " R2 h_front"}, 32'(h_front), 32'(e.hf));
      chk({req, " R2 h_pulse"}, 32'(h_pulse), 32'(e.hp));
      chk({req, " R2 v_back"}, 32'(v_back), 32'(e.vb));
      chk({req, " R2 v_front"}, 32'(v_front), 32'(e.vf));
      chk({req, " R2 v_pulse"}, 32'(v_pulse), 32'(e.vp));
      chk({req, " R3 h_pol"}, 32'(h_pol), 32'(e.hpl));
      chk({req, " R3 v_pol"}, 32'(v_pol), 32'(e.vpl));
      chk({req, " R4 skew"}, 32'(h_skew_out), 32'(e.sk));
      chk({req, " R6 low_porch"}, 32'(low_porch), 32'(e.low));
      chk({req, " R7 fetch_en"}, 32'(fetch_en), 32'(e.fen));
      chk({req, " R7 fetch_start"}, fetch_start, e.fs);
      chk({req, " R1 table err"}, 32'(mode_err), 32'(v.e_err));
      chk({req, " R6 table low"}, 32'(low_porch), 32'(v.e_low));
      chk({req, " R7 table fetch"}, fetch_start, v.e_fs);
      chk({req, " R8 border"}, 32'(border_clr), 32'h0);
      chk({req, " R8 underflow"}, 32'(underflow_clr), 32'hff);
   endtask

   task automatic run_vec(input vec_t v, input string req);
      @(negedge clk);
      drive(v);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done(req);
      compare(v, req);
   endtask

   initial begin
      // R11: reset state
      repeat (3) @(negedge clk);
      chk("R11 busy", 32'(busy), 0);
      chk("R11 done", 32'(done), 0);
      chk("R11 mode_err", 32'(mode_err), 0);
      chk("R11 fetch_en", 32'(fetch_en), 0);
      chk("R11 width", 32'(act_width), 0);
      chk("R8 underflow at reset", 32'(underflow_clr), 32'hff);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11 idle after release", 32'(busy), 0);

      // Table walk: R1..R8
      for (int i = 0; i < 9; i++) begin
         run_vec(TBL[i], $sformatf("vec%0d", i));
         @(negedge clk);
         chk("R9 done one cycle", 32'(done), 0);
      end

      // R9: start held through busy with an invalid mode is ignored
      @(negedge clk);
      drive(TBL[0]);
      start = 1'b1;
      @(negedge clk);
      drive(TBL[6]);
      chk("R9 busy after start", 32'(busy), 1);
      wait_done("R9 hold");
      start = 1'b0;
      compare(TBL[0], "R9 hold");
      begin
         int extra = 0;
         for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (done) extra++;
         end
         chk("R9 no extra done", 32'(extra), 0);
      end

      // R10: start coinciding with done is accepted
      run_vec(TBL[0], "R10 first");
      chk("R10 first fetch_en", 32'(fetch_en), 1);
      drive(TBL[2]);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R10 accepted busy", 32'(busy), 1);
      wait_done("R10 second");
      compare(TBL[2], "R10 second");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule